// File: doc/BRIEF.md
# Byte-Wide Block Cipher Port Adapter

This block sits between a 64-bit block cipher core and a small set of external pins. A device outside the chip loads a 64-bit key one bit at a time through a serial input with a per-bit strobe. It then sends a data block as eight bytes on an 8-bit input bus, each byte qualified by a valid strobe. The adapter assembles the block, latches whether the block is to be encrypted or decrypted, and gives the core a one-cycle start pulse.

The core is seen only as a start/done engine: the adapter holds the block, the key and the direction steady while the core works. It captures the result when the core signals completion, which with the intended core is 16 clock cycles after the start. The result is returned as eight bytes on a separate 8-bit output bus, together with an output-valid flag that marks exactly the cycles carrying result bytes. While a block is in flight, new bytes and key bits are refused. The adapter takes the next block only after the last result byte has left.

Top module: `cipher_byte_port`

## Requirements
- R1: While `rst_n` is low and right after it rises, `outValid`, `coreStart` and `keyLoaded` are 0 and `outByte` is 0.
- R2: Each cycle with `keyStrobe` high that is accepted shifts `keyBit` into the key, first bit ending at key bit 63. `keyLoaded` rises only after exactly 64 accepted strobes, and `coreKey` then equals the key sent.
- R3: A key strobe accepted while `keyLoaded` is 1 starts a fresh load: `keyLoaded` drops at once and 64 strobes are needed again. Key strobes are ignored while part of a block has been collected, while a block is in flight or being output, and in a cycle where an input byte is accepted.
- R4: Input bytes are ignored while `keyLoaded` is 0 and while a block is in flight or being output.
- R5: Bytes are assembled most significant byte first: the first accepted byte becomes `coreBlock[63:56]`. `coreStart` is high for exactly one cycle, the cycle after the eighth byte is accepted, and at that point `coreBlock` holds the assembled block.
- R6: `modeDecrypt` is sampled with the eighth byte only. `coreDecrypt` is 1 for decryption and 0 for encryption, and it holds that value until the block has been output.
- R7: The result is captured in a cycle where `coreDone` is high while a block is in flight, and `outValid` rises in the next cycle. `coreDone` at any other time has no effect.
- R8: `outValid` stays high for exactly 8 consecutive cycles, and `outByte` carries the result most significant byte first, one byte per cycle. After that `outValid` clears and a new block can be accepted.
- R9: `coreKey` and `coreBlock` stay unchanged from the start pulse until `outValid` has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inByte | input | 8 | Plaintext or ciphertext byte |
| inValid | input | 1 | Qualifies `inByte` for one cycle |
| modeDecrypt | input | 1 | 1 selects decryption, 0 encryption; sampled with the eighth byte |
| keyBit | input | 1 | Serial key data |
| keyStrobe | input | 1 | Qualifies `keyBit` for one cycle |
| outByte | output | 8 | Result byte |
| outValid | output | 1 | High while `outByte` carries a result byte |
| keyLoaded | output | 1 | A full 64-bit key is held |
| coreStart | output | 1 | One-cycle start pulse to the core |
| coreBlock | output | 64 | Assembled input block |
| coreKey | output | 64 | Loaded key |
| coreDecrypt | output | 1 | Latched direction |
| coreDone | input | 1 | Core completion pulse |
| coreResult | input | 64 | Core output block, valid with `coreDone` |

## Verification
A wrong byte counter shows at the ports within one block: `coreStart` comes a cycle early or late, or `coreBlock` has its bytes shifted, and both are checked in the cycle after the eighth byte. A wrong key counter or bit order shows as `keyLoaded` rising at a strobe other than the 64th, or as a result that does not match the XOR-style model core in the bench. A mistake in the output sequencer shows as an output run that is not 8 cycles long, or as bytes out of order, and shows up within the eight cycles after completion. Bytes, key bits and completion pulses sent while the adapter should refuse them are checked through the next assembled block and the next result.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  typedef struct packed {
    logic loadByte;       // shift accepted byte into block register
    logic latchMode;      // capture direction with final byte
    logic shiftKey;       // shift serial key bit
    logic captureResult;  // load core result into output register
    logic shiftOut;       // advance output register by one byte
  } cbpStrobes_t;
endpackage

// File: rtl/cbp_ctrl.sv
module cbp_ctrl
  import cbp_pkg::*;
#(
  parameter int BYTES = 8,
  parameter int KEY_W = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        keyStrobe,
  input  logic        coreDone,
  output cbpStrobes_t strobes,
  output logic        keyLoaded,
  output logic        coreStart,
  output logic        outValid
);
  localparam int BCW = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int KCW = $clog2(KEY_W + 1);

  typedef enum logic [1:0] {S_COLLECT, S_START, S_RUN, S_OUT} state_t;

  state_t         state;
  logic [BCW-1:0] byteCnt;
  logic [BCW-1:0] outCnt;
  logic [KCW-1:0] keyCnt;
  logic           byteAccept;
  logic           keyAccept;
  logic           lastByte;
  logic           lastOut;

  assign keyLoaded  = (keyCnt == KCW'(KEY_W));
  assign lastByte   = (byteCnt == BCW'(BYTES - 1));
  assign lastOut    = (outCnt == BCW'(BYTES - 1));
  assign byteAccept = (state == S_COLLECT) && keyLoaded && inValid;
  assign keyAccept  = (state == S_COLLECT) && (byteCnt == '0) && keyStrobe && !byteAccept;

  assign coreStart = (state == S_START);
  assign outValid  = (state == S_OUT);

  always_comb begin
    strobes               = '0;
    strobes.loadByte      = byteAccept;
    strobes.latchMode     = byteAccept && lastByte;
    strobes.shiftKey      = keyAccept;
    strobes.captureResult = (state == S_RUN) && coreDone;
    strobes.shiftOut      = (state == S_OUT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_COLLECT;
      byteCnt <= '0;
      outCnt  <= '0;
      keyCnt  <= '0;
    end else begin
      if (keyAccept) keyCnt <= keyLoaded ? KCW'(1) : keyCnt + KCW'(1);
      unique case (state)
        S_COLLECT: begin
          if (byteAccept) begin
            if (lastByte) begin
              byteCnt <= '0;
              state   <= S_START;
            end else begin
              byteCnt <= byteCnt + BCW'(1);
            end
          end
        end
        S_START: state <= S_RUN;
        S_RUN: begin
          if (coreDone) begin
            outCnt <= '0;
            state  <= S_OUT;
          end
        end
        S_OUT: begin
          if (lastOut) begin
            outCnt <= '0;
            state  <= S_COLLECT;
          end else begin
            outCnt <= outCnt + BCW'(1);
          end
        end
        default: state <= S_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/cbp_dp.sv
module cbp_dp
  import cbp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 8,
  parameter int KEY_W  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  cbpStrobes_t              strobes,
  input  logic [BYTE_W-1:0]        inByte,
  input  logic                     modeDecrypt,
  input  logic                     keyBit,
  input  logic [BYTE_W*BYTES-1:0]  coreResult,
  output logic [BYTE_W-1:0]        outByte,
  output logic [BYTE_W*BYTES-1:0]  coreBlock,
  output logic [KEY_W-1:0]         coreKey,
  output logic                     coreDecrypt
);
  localparam int BLOCK_W = BYTE_W * BYTES;

  logic [BLOCK_W-1:0] blockReg;
  logic [BLOCK_W-1:0] outReg;
  logic [KEY_W-1:0]   keyReg;
  logic               modeReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blockReg <= '0;
      outReg   <= '0;
      keyReg   <= '0;
      modeReg  <= 1'b0;
    end else begin
      if (strobes.loadByte)  blockReg <= {blockReg[BLOCK_W-BYTE_W-1:0], inByte};
      if (strobes.latchMode) modeReg  <= modeDecrypt;
      if (strobes.shiftKey)  keyReg   <= {keyReg[KEY_W-2:0], keyBit};
      if (strobes.captureResult)
        outReg <= coreResult;
      else if (strobes.shiftOut)
        outReg <= {outReg[BLOCK_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
    end
  end

  assign outByte     = outReg[BLOCK_W-1 -: BYTE_W];
  assign coreBlock   = blockReg;
  assign coreKey     = keyReg;
  assign coreDecrypt = modeReg;
endmodule

// File: rtl/cipher_byte_port.sv
module cipher_byte_port
  import cbp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 8,
  parameter int KEY_W  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BYTE_W-1:0]        inByte,
  input  logic                     inValid,
  input  logic                     modeDecrypt,
  input  logic                     keyBit,
  input  logic                     keyStrobe,
  output logic [BYTE_W-1:0]        outByte,
  output logic                     outValid,
  output logic                     keyLoaded,
  output logic                     coreStart,
  output logic [BYTE_W*BYTES-1:0]  coreBlock,
  output logic [KEY_W-1:0]         coreKey,
  output logic                     coreDecrypt,
  input  logic                     coreDone,
  input  logic [BYTE_W*BYTES-1:0]  coreResult
);
  cbpStrobes_t strobes;

  cbp_ctrl #(.BYTES(BYTES), .KEY_W(KEY_W)) ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .keyStrobe(keyStrobe),
    .coreDone(coreDone), .strobes(strobes), .keyLoaded(keyLoaded),
    .coreStart(coreStart), .outValid(outValid)
  );

  cbp_dp #(.BYTE_W(BYTE_W), .BYTES(BYTES), .KEY_W(KEY_W)) dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .inByte(inByte),
    .modeDecrypt(modeDecrypt), .keyBit(keyBit), .coreResult(coreResult),
    .outByte(outByte), .coreBlock(coreBlock), .coreKey(coreKey),
    .coreDecrypt(coreDecrypt)
  );
endmodule

// File: rtl/cbp_chk.sv
module cbp_chk #(
  parameter int BYTES   = 8,
  parameter int BLOCK_W = 64,
  parameter int KEY_W   = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               coreStart,
  input logic               keyLoaded,
  input logic               outValid,
  input logic               coreDone,
  input logic               coreDecrypt,
  input logic [BLOCK_W-1:0] coreBlock,
  input logic [KEY_W-1:0]   coreKey
);
  localparam int RW = $clog2(BYTES + 1) + 1;
  logic [RW-1:0] runLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) runLen <= '0;
    else        runLen <= outValid ? runLen + RW'(1) : '0;
  end

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coreStart |=> !coreStart);

  // R2
  start_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coreStart |-> keyLoaded);

  // R7
  out_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outValid) |-> $past(coreDone));

  // R8
  out_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(outValid) |-> (runLen == RW'(BYTES)));

  // R8
  out_run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    runLen <= RW'(BYTES));

  // R9
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coreStart || outValid) |=> ($stable(coreKey) && $stable(coreBlock)));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coreStart || outValid) |=> $stable(coreDecrypt));
endmodule

bind cipher_byte_port cbp_chk #(.BYTES(BYTES), .BLOCK_W(BYTE_W*BYTES), .KEY_W(KEY_W)) chk (
  .clk(clk), .rst_n(rst_n), .coreStart(coreStart), .keyLoaded(keyLoaded),
  .outValid(outValid), .coreDone(coreDone), .coreDecrypt(coreDecrypt),
  .coreBlock(coreBlock), .coreKey(coreKey)
);

// File: tb/cipher_byte_port_test.sv
`timescale 1ns/1ps
module cipher_byte_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  inByte = '0;
  logic        inValid = 1'b0;
  logic        modeDecrypt = 1'b0;
  logic        keyBit = 1'b0;
  logic        keyStrobe = 1'b0;
  logic [7:0]  outByte;
  logic        outValid;
  logic        keyLoaded;
  logic        coreStart;
  logic [63:0] coreBlock;
  logic [63:0] coreKey;
  logic        coreDecrypt;
  logic        coreDone;
  logic [63:0] coreResult;
  logic        spurDone = 1'b0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  cipher_byte_port uut (
    .clk(clk), .rst_n(rst_n), .inByte(inByte), .inValid(inValid),
    .modeDecrypt(modeDecrypt), .keyBit(keyBit), .keyStrobe(keyStrobe),
    .outByte(outByte), .outValid(outValid), .keyLoaded(keyLoaded),
    .coreStart(coreStart), .coreBlock(coreBlock), .coreKey(coreKey),
    .coreDecrypt(coreDecrypt), .coreDone(coreDone), .coreResult(coreResult)
  );

  // model core: done 16 cycles after start, result is an XOR mix
  logic [4:0] coreCnt = '0;
  always_ff @(posedge clk) begin
    if (coreStart)           coreCnt <= 5'd16;
    else if (coreCnt != '0)  coreCnt <= coreCnt - 5'd1;
  end
  assign coreDone   = (coreCnt == 5'd1) || spurDone;
  assign coreResult = coreDecrypt ? (coreBlock ^ ~coreKey) : (coreBlock ^ coreKey);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic sendKey(input logic [63:0] k);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (i == 1)  check(keyLoaded == 1'b0, "R3 load in progress after one strobe", 64'(keyLoaded), 64'd0);
      if (i == 63) check(keyLoaded == 1'b0, "R2 not loaded after 63 strobes", 64'(keyLoaded), 64'd0);
      keyBit = k[63-i];
      keyStrobe = 1'b1;
    end
    @(negedge clk);
    keyStrobe = 1'b0;
    check(keyLoaded == 1'b1, "R2 loaded after 64 strobes", 64'(keyLoaded), 64'd1);
    check(coreKey == k, "R2 key MSB first", coreKey, k);
  endtask

  // opt: 1 = key strobe with first byte, 2 = key strobes in the middle of the block
  task automatic sendBlock(input logic [63:0] blk, input bit mode, input int opt);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      inByte = blk[63-8*i -: 8];
      inValid = 1'b1;
      modeDecrypt = (i == 7) ? mode : ~mode;
      keyStrobe = (opt == 1 && i == 0);
      keyBit = 1'b1;
      if (opt == 2 && i == 3) begin
        inValid = 1'b0;
        keyStrobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        keyStrobe = 1'b0;
        check(keyLoaded == 1'b1, "R3 key strobe ignored mid-block", 64'(keyLoaded), 64'd1);
        inValid = 1'b1;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    keyStrobe = 1'b0;
    check(coreStart == 1'b1, "R5 start after eighth byte", 64'(coreStart), 64'd1);
    check(coreBlock == blk, "R5 block MSB byte first", coreBlock, blk);
    check(coreDecrypt == mode, "R6 mode latched with eighth byte", 64'(coreDecrypt), 64'(mode));
    @(negedge clk);
    check(coreStart == 1'b0, "R5 start one cycle", 64'(coreStart), 64'd0);
  endtask

  // junk: drive ignored bytes and key strobes while busy
  task automatic receive(input logic [63:0] exp, input bit junk);
    int w = 0;
    if (junk) begin
      inByte = 8'hEE;
      inValid = 1'b1;
      keyStrobe = 1'b1;
    end
    while (!outValid && w < 40) begin
      @(negedge clk);
      w++;
    end
    check(outValid == 1'b1, "R7 output arrives", 64'(outValid), 64'd1);
    for (int i = 0; i < 8; i++) begin
      check(outValid == 1'b1, "R8 outValid held", 64'(outValid), 64'd1);
      check(outByte == exp[63-8*i -: 8], "R8 output byte order", 64'(outByte), 64'(exp[63-8*i -: 8]));
      if (i == 7) begin
        inValid = 1'b0;
        keyStrobe = 1'b0;
      end
      @(negedge clk);
    end
    check(outValid == 1'b0, "R8 outValid clears after 8", 64'(outValid), 64'd0);
  endtask

  function automatic logic [63:0] mkBlock(input int s);
    logic [63:0] b;
    for (int j = 0; j < 8; j++) b[8*j +: 8] = 8'((s * 37 + j * 91 + 5) ^ (j << 4));
    return b;
  endfunction

  initial begin
    logic [63:0] key;
    logic [63:0] key2;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && coreStart == 1'b0 && keyLoaded == 1'b0 && outByte == 8'h00,
          "R1 reset state", {outByte, 53'd0, outValid, coreStart, keyLoaded}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && coreStart == 1'b0 && keyLoaded == 1'b0,
          "R1 after reset", {61'd0, outValid, coreStart, keyLoaded}, 64'd0);

    // R4: bytes without key are dropped
    for (int i = 0; i < 10; i++) begin
      inByte = 8'(i + 8'hA0);
      inValid = 1'b1;
      @(negedge clk);
    end
    inValid = 1'b0;
    check(coreStart == 1'b0, "R4 no start without key", 64'(coreStart), 64'd0);

    key = 64'h0123_4567_89AB_CDEF;
    sendKey(key);

    // R7: completion pulse while idle is ignored
    spurDone = 1'b1;
    @(negedge clk);
    spurDone = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R7 idle done ignored", 64'(outValid), 64'd0);

    // sweep blocks and both directions
    for (int s = 0; s < 6; s++) begin
      for (int m = 0; m < 2; m++) begin
        logic [63:0] blk;
        blk = mkBlock(s * 2 + m);
        sendBlock(blk, m[0], (s == 2) ? 1 : (s == 3 ? 2 : 0));
        receive(m[0] ? (blk ^ ~key) : (blk ^ key), (s == 1));
      end
    end
    // R3: priority, mid-block and busy strobes left key intact
    check(coreKey == key, "R3 key unchanged by ignored strobes", coreKey, key);

    // edge patterns
    sendBlock(64'h0, 1'b0, 0);
    receive(key, 1'b0);
    sendBlock(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 0);
    receive(64'hFFFF_FFFF_FFFF_FFFF ^ ~key, 1'b0);

    // R3: reload a new key
    key2 = 64'hF0E1_D2C3_B4A5_9687;
    sendKey(key2);
    sendBlock(64'h1122_3344_5566_7788, 1'b0, 0);
    receive(64'h1122_3344_5566_7788 ^ key2, 1'b0);
    check(outByte == 8'h00, "R8 idle output byte", 64'(outByte), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule